// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a queue of up to sixteen commands once it is started, with no further attention from the host. Each command carries up to sixteen bits of transmit data, a transfer length from 8 to 16 bits and a 4-bit encoded device-select value. The host fills the command queue through a simple write port, sets the first and last queue index, and pulses `go`. The block then performs each transfer in index order. Every received word is stored in a receive queue at the same index as its command.

Clock polarity and phase, the serial clock divisor, the wait between select assertion and the first clock edge, and the wait after each transfer all come from configuration inputs. These inputs must stay stable while `busy` is high. The device-select lines carry an encoded value in which all-ones means that no device is selected, so fifteen devices can be addressed. When the wrap option is set, the queue restarts at the first index after the last one and runs without stopping. Otherwise a done flag, and an interrupt if it is enabled, is raised when the last command completes. Only master operation is provided.

Top module: `qspi_seq`

## Requirements
- R1: After reset, `dev_sel` is 4'hF, `busy`, `done`, `irq` and `mosi` are 0, and `sck` equals `cfg_cpol`.
- R2: The effective transfer length L is `cmd_len` clamped to the range 8..16. The low L bits of the data are sent MSB first, and exactly 2L serial clock edges are produced per command.
- R3: The L bits received on `miso` are stored right-aligned, with the upper bits zero, in the receive queue at the command's index. They are readable combinationally on `rx_data` from `rx_addr`.
- R4: `sck` idles at `cfg_cpol`. With `cfg_cpha`=0, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cfg_cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R5: Consecutive serial clock edges are N clock cycles apart, where N is `cfg_baud`, and values below 2 count as 2.
- R6: The first serial clock edge of a command comes exactly `cfg_pre`+N+1 clock cycles after `dev_sel` takes that command's select value.
- R7: With `cfg_hold_sel`=0, `dev_sel` returns to 4'hF exactly `cfg_post`+2 clock cycles after the command's last serial clock edge.
- R8: During a command, `dev_sel` shows that command's select value. Between commands it returns to 4'hF, unless `cfg_hold_sel`=1, in which case the select stays asserted until the queue finishes.
- R9: Commands run from `q_start` to `q_end`, with the index stepping by one and going from 15 back to 0.
- R10: When the command at `q_end` completes with wrap off, `busy` falls and `done` rises on the same edge as the final deselect. `irq` equals `done` when `cfg_irq_en`=1 and is 0 otherwise. `go` clears `done`.
- R11: With `cfg_wrap`=1, the command at `q_start` follows the command at `q_end`, operation continues, and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_baud | input | 8 | Half-period divisor N |
| cfg_pre | input | 8 | Extra cycles from select to first edge |
| cfg_post | input | 8 | Extra cycles after last edge |
| cfg_wrap | input | 1 | Restart queue after the last index |
| cfg_hold_sel | input | 1 | Keep the select asserted between commands |
| cfg_irq_en | input | 1 | Interrupt enable |
| q_start | input | 4 | First queue index |
| q_end | input | 4 | Last queue index |
| go | input | 1 | Start pulse, taken only while idle |
| cmd_we | input | 1 | Command queue write enable |
| cmd_addr | input | 4 | Command queue write index |
| cmd_data | input | 16 | Transmit data |
| cmd_len | input | 5 | Requested transfer length |
| cmd_sel | input | 4 | Encoded device select |
| rx_addr | input | 4 | Receive queue read index |
| rx_data | output | 16 | Received word at `rx_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| dev_sel | output | 4 | Encoded device select, 4'hF for none |
| busy | output | 1 | Queue is running |
| done | output | 1 | Queue finished (sticky until the next `go`) |
| irq | output | 1 | Completion interrupt |

## Verification
The block's timing is fixed in clock cycles. The select value appears on the edge after a command is fetched. The first serial edge follows it by `cfg_pre`+N+1 cycles, later edges are N cycles apart, and the deselect together with `done` follows the last edge by `cfg_post`+2 cycles. The bench stamps every `sck` and `dev_sel` change with a cycle count that advances on the falling clock edge, so the stamps are taken from settled values. It then compares the differences between stamps with these formulas. Received words are read back once the queue is idle.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_PRE   = 3'd2,
    S_SHIFT = 3'd3,
    S_POST  = 3'd4,
    S_ADV   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/qspi_regfile.sv
// Flop-based storage with one write port and a combinational read port.
module qspi_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qspi_baud.sv
// Half-period timer: tick marks the cycle at the end of which sck toggles.
module qspi_baud #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] half, hc_q, hc_n;

  assign half = (div < DIVW'(2)) ? DIVW'(2) : div;
  assign tick = run && (hc_q == '0);

  always_comb begin
    if (!run || hc_q == '0) hc_n = half - DIVW'(1);
    else                    hc_n = hc_q - DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_n;
  end
endmodule

// File: rtl/qspi_shift.sv
// Transmit and receive shifters. The launch edge and sample edge are chosen by phase.
module qspi_shift #(
  parameter int DW   = 16,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   load_data,
  input  logic [LENW-1:0] load_len,
  input  logic            cpha,
  input  logic            tick,
  input  logic            lead,
  input  logic            miso,
  output logic            mosi,
  output logic [DW-1:0]   rx_word
);
  logic [DW-1:0]   tx_q, tx_n, rx_q, tx_al;
  logic [LENW-1:0] sh;
  logic            mosi_q, mosi_n, launch;

  assign sh      = LENW'(DW) - load_len;
  assign tx_al   = load_data << sh;
  assign launch  = cpha ? lead : !lead;
  assign rx_word = (tick && !launch) ? {rx_q[DW-2:0], miso} : rx_q;
  assign mosi    = mosi_q;

  always_comb begin
    tx_n   = tx_q;
    mosi_n = mosi_q;
    if (load) begin
      if (cpha) begin
        tx_n   = tx_al;
        mosi_n = 1'b0;
      end else begin
        tx_n   = tx_al << 1;
        mosi_n = tx_al[DW-1];
      end
    end else if (tick && launch) begin
      tx_n   = tx_q << 1;
      mosi_n = tx_q[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_n;
      rx_q   <= load ? '0 : rx_word;
      mosi_q <= mosi_n;
    end
  end
endmodule

// File: rtl/qspi_seq.sv
// Queue sequencer: fetches commands in index order and runs each transfer.
module qspi_seq #(
  parameter int DEPTH  = 16,
  parameter int DW     = 16,
  parameter int MINLEN = 8,
  parameter int LENW   = 5,
  parameter int SELW   = 4,
  parameter int DIVW   = 8,
  parameter int DLYW   = 8,
  localparam int PTRW  = $clog2(DEPTH),
  localparam int CMDW  = DW + LENW + SELW,
  localparam int ECW   = LENW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [DIVW-1:0] cfg_baud,
  input  logic [DLYW-1:0] cfg_pre,
  input  logic [DLYW-1:0] cfg_post,
  input  logic            cfg_wrap,
  input  logic            cfg_hold_sel,
  input  logic            cfg_irq_en,
  input  logic [PTRW-1:0] q_start,
  input  logic [PTRW-1:0] q_end,
  input  logic            go,
  input  logic            cmd_we,
  input  logic [PTRW-1:0] cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  input  logic [LENW-1:0] cmd_len,
  input  logic [SELW-1:0] cmd_sel,
  input  logic [PTRW-1:0] rx_addr,
  output logic [DW-1:0]   rx_data,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic [SELW-1:0] dev_sel,
  output logic            busy,
  output logic            done,
  output logic            irq
);
  import qspi_pkg::*;

  localparam logic [SELW-1:0] SEL_NONE = {SELW{1'b1}};

  seq_state_e      state_q, state_n;
  logic [PTRW-1:0] ptr_q, ptr_n, ptr_inc;
  logic [DLYW-1:0] dcnt_q, dcnt_n;
  logic [ECW-1:0]  ecnt_q, ecnt_n;
  logic [LENW-1:0] len_q, len_n, raw_len, len_eff;
  logic [SELW-1:0] sel_q, sel_n;
  logic            sck_q, sck_n, done_q, done_n;
  logic [CMDW-1:0] cmd_rd;
  logic [DW-1:0]   rx_word;
  logic            tick, run, load, last_edge, rx_we;

  qspi_regfile #(.W(CMDW), .DEPTH(DEPTH)) u_cmdq (
    .clk(clk), .we(cmd_we), .waddr(cmd_addr),
    .wdata({cmd_data, cmd_len, cmd_sel}),
    .raddr(ptr_q), .rdata(cmd_rd)
  );

  qspi_regfile #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .we(rx_we), .waddr(ptr_q), .wdata(rx_word),
    .raddr(rx_addr), .rdata(rx_data)
  );

  qspi_baud #(.DIVW(DIVW)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(cfg_baud), .tick(tick)
  );

  qspi_shift #(.DW(DW), .LENW(LENW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_data(cmd_rd[CMDW-1 -: DW]), .load_len(len_eff),
    .cpha(cfg_cpha), .tick(tick), .lead(~ecnt_q[0]), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  // Length clamp into the supported range
  assign raw_len = cmd_rd[SELW +: LENW];
  always_comb begin
    if (raw_len < LENW'(MINLEN))  len_eff = LENW'(MINLEN);
    else if (raw_len > LENW'(DW)) len_eff = LENW'(DW);
    else                          len_eff = raw_len;
  end

  generate
    if ((1 << PTRW) == DEPTH) begin : g_pow2
      assign ptr_inc = ptr_q + PTRW'(1);
    end else begin : g_mod
      assign ptr_inc = (ptr_q == PTRW'(DEPTH - 1)) ? '0 : ptr_q + PTRW'(1);
    end
  endgenerate

  assign run       = (state_q == S_SHIFT);
  assign load      = (state_q == S_LOAD);
  assign last_edge = (ecnt_q == ({len_q, 1'b0} - ECW'(1)));
  assign rx_we     = run && tick && last_edge;

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    dcnt_n  = dcnt_q;
    ecnt_n  = ecnt_q;
    len_n   = len_q;
    sel_n   = sel_q;
    sck_n   = sck_q;
    done_n  = done_q;
    unique case (state_q)
      S_IDLE: if (go) begin
        ptr_n   = q_start;
        done_n  = 1'b0;
        state_n = S_LOAD;
      end
      S_LOAD: begin
        sel_n   = cmd_rd[SELW-1:0];
        len_n   = len_eff;
        dcnt_n  = cfg_pre;
        ecnt_n  = '0;
        state_n = S_PRE;
      end
      S_PRE: begin
        if (dcnt_q == '0) state_n = S_SHIFT;
        else              dcnt_n  = dcnt_q - DLYW'(1);
      end
      S_SHIFT: if (tick) begin
        sck_n  = ~sck_q;
        ecnt_n = ecnt_q + ECW'(1);
        if (last_edge) begin
          dcnt_n  = cfg_post;
          state_n = S_POST;
        end
      end
      S_POST: begin
        if (dcnt_q == '0) state_n = S_ADV;
        else              dcnt_n  = dcnt_q - DLYW'(1);
      end
      S_ADV: begin
        if (!cfg_hold_sel) sel_n = SEL_NONE;
        if (ptr_q != q_end) begin
          ptr_n   = ptr_inc;
          state_n = S_LOAD;
        end else if (cfg_wrap) begin
          ptr_n   = q_start;
          state_n = S_LOAD;
        end else begin
          sel_n   = SEL_NONE;
          done_n  = 1'b1;
          state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      dcnt_q  <= '0;
      ecnt_q  <= '0;
      len_q   <= LENW'(MINLEN);
      sel_q   <= SEL_NONE;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      dcnt_q  <= dcnt_n;
      ecnt_q  <= ecnt_n;
      len_q   <= len_n;
      sel_q   <= sel_n;
      sck_q   <= sck_n;
      done_q  <= done_n;
    end
  end

  assign sck     = sck_q ^ cfg_cpol;
  assign dev_sel = sel_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign irq     = done_q & cfg_irq_en;
endmodule

// File: rtl/qspi_seq_chk.sv
module qspi_seq_chk #(
  parameter int SELW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                go,
  input logic                busy,
  input logic                done,
  input logic                sck,
  input logic                cfg_cpol,
  input logic                cfg_wrap,
  input logic [SELW-1:0]     dev_sel,
  input qspi_pkg::seq_state_e state
);
  import qspi_pkg::*;

  // R8: nothing is selected while the queue is idle
  assert_idle_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dev_sel == {SELW{1'b1}});

  // R4: the serial clock rests at its polarity level when idle
  assert_idle_sck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cfg_cpol);

  // R10: a start clears the completion flag
  assert_go_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (busy && !done));

  // R10: completion coincides with the end of the run
  assert_done_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R11: a wrapping queue never reports completion
  assert_wrap_nodone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wrap) |=> !done);

  // R6: no serial clock edge during the pre-transfer wait
  assert_pre_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PRE) |=> $stable(sck));
endmodule

bind qspi_seq qspi_seq_chk #(.SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .sck(sck), .cfg_cpol(cfg_cpol), .cfg_wrap(cfg_wrap),
  .dev_sel(dev_sel), .state(state_q)
);

// File: tb/qspi_seq_tb.sv
module qspi_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_cpol = 0, cfg_cpha = 0, cfg_wrap = 0, cfg_hold_sel = 0, cfg_irq_en = 0;
  logic [7:0] cfg_baud = 0, cfg_pre = 0, cfg_post = 0;
  logic [3:0] q_start = 0, q_end = 0, cmd_addr = 0, cmd_sel = 0, rx_addr = 0;
  logic go = 0, cmd_we = 0, miso = 0;
  logic [15:0] cmd_data = 0;
  logic [4:0] cmd_len = 0;
  logic [15:0] rx_data;
  logic sck, mosi, busy, done, irq;
  logic [3:0] dev_sel;

  qspi_seq u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  int exp_idx[64], exp_len[64];
  logic [15:0] exp_dat[64], exp_pat[64];
  logic [3:0] exp_cs[64];
  int t_first[64], t_last[64], sel_on[64], sel_off[64];
  logic [3:0] sel_at[64];
  logic [15:0] got[64];
  bit gap_bad[64];
  int k = 0, e = 0, bitp = 0, t_prev = 0, n_on = 0, n_off = 0, n_done = 0, t_done = 0;
  logic [15:0] cap = 0;
  logic [3:0] prev_sel = 4'hF;
  bit lead_b, launch_b;

  function automatic int eff(input int l);
    return (l < 8) ? 8 : ((l > 16) ? 16 : l);
  endfunction
  function automatic int neff(input int b);
    return (b < 2) ? 2 : b;
  endfunction
  function automatic logic [15:0] msk(input int l);
    return 16'((32'h1 << eff(l)) - 1);
  endfunction

  function void prep();
    e = 0; cap = '0;
    if (k < 64) begin
      bitp = eff(exp_len[k]) - 1;
      miso = cfg_cpha ? 1'b0 : exp_pat[k][bitp];
    end
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Slave model: responds with exp_pat and captures mosi on the sample edges
  always @(sck) begin
    if (rst_n && busy && k < 64) begin
      lead_b   = (sck != cfg_cpol);
      launch_b = cfg_cpha ? lead_b : !lead_b;
      if (e == 0) begin
        t_first[k] = cyc; sel_at[k] = dev_sel; gap_bad[k] = 0;
      end else if (cyc - t_prev != neff(cfg_baud)) gap_bad[k] = 1;
      t_prev = cyc;
      if (!launch_b) cap = {cap[14:0], mosi};
      else if (cfg_cpha) begin miso = exp_pat[k][bitp]; bitp--; end
      else begin bitp--; if (bitp >= 0) miso = exp_pat[k][bitp]; end
      e++;
      if (e == 2 * eff(exp_len[k])) begin
        t_last[k] = cyc; got[k] = cap; k++; prep();
      end
    end
  end

  always @(dev_sel) begin
    if (rst_n) begin
      if (dev_sel != 4'hF && prev_sel == 4'hF) begin
        if (k < 64) sel_on[k] = cyc;
        n_on++;
      end
      if (dev_sel == 4'hF && prev_sel != 4'hF) begin
        if (k > 0) sel_off[k-1] = cyc;
        n_off++;
      end
    end
    prev_sel = dev_sel;
  end

  always @(posedge done) begin
    t_done = cyc; n_done++;
  end

  task automatic put(input int idx, input logic [15:0] d, input int len, input logic [3:0] cs);
    @(negedge clk);
    cmd_we = 1; cmd_addr = 4'(idx); cmd_data = d; cmd_len = 5'(len); cmd_sel = cs;
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic launch(input int ntr, input bit wrap);
    n_on = 0; n_off = 0; n_done = 0; k = 0; prep();
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
    for (int i = 0; i < 30000; i++) begin
      if (wrap ? (k >= ntr) : (done === 1'b1)) break;
      @(negedge clk);
    end
    if (wrap ? (k < ntr) : (done !== 1'b1)) chk("R10", "queue run timed out", 0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R8", $sformatf("select of transfer %0d", i), sel_at[i], exp_cs[i]);
      chk("R2", $sformatf("mosi word of transfer %0d", i), got[i], exp_dat[i] & msk(exp_len[i]));
      chk("R5", $sformatf("edge spacing of transfer %0d", i), gap_bad[i], 0);
    end
  endtask

  task automatic check_rx(input int n);
    for (int i = 0; i < n; i++) begin
      rx_addr = 4'(exp_idx[i]);
      #1;
      chk("R3", $sformatf("rx word at index %0d", exp_idx[i]), rx_data, exp_pat[i] & msk(exp_len[i]));
    end
  endtask

  task automatic check_reset();
    chk("R1", "dev_sel after reset", dev_sel, 4'hF);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "mosi after reset", mosi, 0);
    chk("R1", "sck after reset", sck, cfg_cpol);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_reset();

    // Sweep over the four clock modes, all lengths 8..16, several divisors and delays
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[1]; cfg_cpha = m[0];
      cfg_baud = (m == 0) ? 8'd0 : (m == 1) ? 8'd1 : (m == 2) ? 8'd3 : 8'd5;
      cfg_pre = 8'(2 * m); cfg_post = 8'(3 - m);
      cfg_irq_en = (m != 2); cfg_hold_sel = 0; cfg_wrap = 0;
      q_start = 0; q_end = 8;
      for (int i = 0; i < 9; i++) begin
        exp_idx[i] = i; exp_len[i] = 8 + i;
        exp_dat[i] = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(m);
        exp_pat[i] = 16'h3C96 + 16'(i * 16'h00F1) + 16'(m * 7);
        exp_cs[i]  = 4'(i ^ m);
        put(i, exp_dat[i], exp_len[i], exp_cs[i]);
      end
      launch(9, 0);
      check_data(9);
      check_rx(9);
      for (int i = 0; i < 9; i++) begin
        chk("R6", $sformatf("select to first edge, transfer %0d", i),
            t_first[i] - sel_on[i], cfg_pre + neff(cfg_baud) + 1);
        chk("R7", $sformatf("last edge to deselect, transfer %0d", i),
            sel_off[i] - t_last[i], cfg_post + 2);
      end
      chk("R2", "transfer count", k, 9);
      chk("R9", "select count in order", n_on, 9);
      chk("R10", "done set", done, 1);
      chk("R10", "irq gated by enable", irq, cfg_irq_en);
      chk("R10", "done on final deselect edge", t_done, sel_off[8]);
      chk("R10", "busy cleared", busy, 0);
      chk("R4", "sck idle level", sck, cfg_cpol);
    end

    // Length clamp, index roll-over and held select
    cfg_cpol = 0; cfg_cpha = 1; cfg_baud = 2; cfg_pre = 1; cfg_post = 0;
    cfg_hold_sel = 1; cfg_irq_en = 1; q_start = 14; q_end = 1;
    for (int i = 0; i < 4; i++) begin
      exp_idx[i] = (14 + i) % 16;
      exp_len[i] = (i == 0) ? 0 : (i == 1) ? 5 : (i == 2) ? 17 : 31;
      exp_dat[i] = 16'hF00F ^ 16'(i * 16'h2461);
      exp_pat[i] = 16'h9A5B ^ 16'(i * 16'h1111);
      exp_cs[i]  = 4'h6;
      put(exp_idx[i], exp_dat[i], exp_len[i], exp_cs[i]);
    end
    launch(4, 0);
    check_data(4);
    check_rx(4);
    chk("R9", "rolled-over transfer count", k, 4);
    chk("R8", "held select asserts once", n_on, 1);
    chk("R8", "held select releases once", n_off, 1);
    chk("R10", "done after held run", done, 1);

    // Wraparound: indices 5,6 repeat with no completion
    cfg_cpol = 1; cfg_cpha = 0; cfg_baud = 0; cfg_pre = 0; cfg_post = 0;
    cfg_hold_sel = 0; cfg_wrap = 1; q_start = 5; q_end = 6;
    put(5, 16'h0ABC, 12, 4'h2);
    put(6, 16'h01C5, 9, 4'h9);
    for (int i = 0; i < 64; i++) begin
      exp_idx[i] = 5 + (i % 2);
      exp_len[i] = (i % 2) ? 9 : 12;
      exp_dat[i] = (i % 2) ? 16'h01C5 : 16'h0ABC;
      exp_pat[i] = (i % 2) ? 16'h0133 : 16'h0E71;
      exp_cs[i]  = (i % 2) ? 4'h9 : 4'h2;
    end
    launch(6, 1);
    check_data(6);
    chk("R11", "no completion while wrapping", n_done, 0);
    chk("R11", "still running", busy, 1);
    chk("R11", "first index revisited", sel_at[4], 4'h2);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_rx(2);
    cfg_wrap = 0;
    check_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule